// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block decides when an analog-to-digital converter begins a conversion. It holds an 8-bit control register that selects one of eight trigger sources, turns auto-triggering and the converter on or off, and holds the conversion-complete flag. Seven sources are one-bit event flags that come from other blocks. The eighth, code 000, is free running: here the trigger signal is the block's own conversion-complete flag.

The selected source goes through a multiplexer and then through a single edge detector. A rising edge therefore comes either from the source itself or from a change of selection that moves from a low flag to a high one. Entering free running is the exception: it never triggers by itself. When a qualified edge arrives, a sequencer with two states, `ST_IDLE` and `ST_CONVERT`, issues a start pulse one cycle long and raises busy. It has three transitions: *launch* goes from `ST_IDLE` to `ST_CONVERT` on a trigger while the converter is enabled. *finish* goes from `ST_CONVERT` to `ST_IDLE` on the complete strobe. *abort* goes from `ST_CONVERT` to `ST_IDLE` when the converter enable is cleared. In every other case the sequencer stays where it is (*hold*).

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset the control register reads 8'h00, and `start_pulse` and `busy` are 0.
- R2: Register layout: bits [2:0] hold the source code, bit 3 is auto-trigger enable, bit 4 is converter enable and bit 5 is the complete flag. Code k (1..7) selects `evt_flags[k]`, and code 0 selects free running on the complete flag.
- R3: Only a 0-to-1 change of the selected source starts a conversion. A source that stays high starts nothing more.
- R4: While auto-trigger enable is 0, no source and no change of selection produces a start.
- R5: While converter enable is 0, no start is issued. Clearing it in `ST_CONVERT` takes the sequencer back to `ST_IDLE` one cycle later (abort).
- R6: Changing the selection from a source whose flag is 0 to one whose flag is 1 starts a conversion.
- R7: Entering free running never triggers by itself, even when the complete flag is already 1. This covers a write of code 0 with auto enabled, and also setting auto enable while the code is 0.
- R8: In free running, each rising edge of the complete flag starts the next conversion.
- R9: `start_pulse` is high for exactly one cycle, in the cycle after the trigger edge. `busy` rises with it and falls in the cycle after `conv_done`.
- R10: A trigger edge that arrives while busy is dropped and is not held for later.
- R11: `conv_done` sets the complete flag, and writing 1 to bit 5 clears it. When both happen in the same cycle, the flag stays set.
- R12: Bits 7 and 6 always read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_flags | input | 7 | Event flags; bit k is source code k (1..7) |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| conv_done | input | 1 | Conversion-complete strobe from the converter |
| start_pulse | output | 1 | One-cycle start-conversion pulse |
| busy | output | 1 | Conversion in progress |

## Verification
The hardest case to reach is a free-running chain. The complete flag has to be cleared by software while a conversion is still running, so that the next `conv_done` gives a fresh rising edge at the same moment the sequencer returns to idle. The bench starts free running from an already-set flag and checks that this is silent. It then clears the flag, pulses `conv_done` to get the first start, clears the flag again while busy, and pulses `conv_done` once more. This second start is the one that must follow at once. The same-cycle clear-and-set race is driven with the register write and `conv_done` asserted on the same edge.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
    localparam int SEL_W    = 3;
    localparam int N_SRC    = 1 << SEL_W;
    localparam int REG_W    = 8;
    localparam int SEL_LSB  = 0;
    localparam int AUTO_BIT = SEL_LSB + SEL_W;
    localparam int ENA_BIT  = AUTO_BIT + 1;
    localparam int FLAG_BIT = ENA_BIT + 1;
    localparam int RESV_LSB = FLAG_BIT + 1;

    typedef enum logic [SEL_W-1:0] {
        SRC_FREE    = 3'd0,
        SRC_ACOMP   = 3'd1,
        SRC_EXTIRQ  = 3'd2,
        SRC_T0_CMP  = 3'd3,
        SRC_T0_OVF  = 3'd4,
        SRC_T1_CMPB = 3'd5,
        SRC_T1_OVF  = 3'd6,
        SRC_T1_CAP  = 3'd7
    } trig_src_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_CONVERT = 1'b1
    } conv_state_e;

    typedef struct packed {
        trig_src_e sel;
        logic      auto_en;
        logic      conv_en;
    } ctrl_t;
endpackage

// File: rtl/adc_trig_regs.sv
module adc_trig_regs
    import adc_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             set_done,
    output ctrl_t            ctrl,
    output logic             done_flag,
    output logic [REG_W-1:0] rdata
);
    logic unused_resv;
    assign unused_resv = ^wdata[REG_W-1:RESV_LSB];

    // control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl.sel     <= SRC_FREE;
            ctrl.auto_en <= 1'b0;
            ctrl.conv_en <= 1'b0;
        end else if (wr_en) begin
            ctrl.sel     <= trig_src_e'(wdata[SEL_LSB +: SEL_W]);
            ctrl.auto_en <= wdata[AUTO_BIT];
            ctrl.conv_en <= wdata[ENA_BIT];
        end
    end

    // complete flag: set has priority over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
        end else if (set_done) begin
            done_flag <= 1'b1;
        end else if (wr_en && wdata[FLAG_BIT]) begin
            done_flag <= 1'b0;
        end
    end

    always_comb begin
        rdata                      = '0;
        rdata[SEL_LSB +: SEL_W]    = ctrl.sel;
        rdata[AUTO_BIT]            = ctrl.auto_en;
        rdata[ENA_BIT]             = ctrl.conv_en;
        rdata[FLAG_BIT]            = done_flag;
    end

    assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> done_flag);
    assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[FLAG_BIT] && !set_done) |=> !done_flag);
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge
    import adc_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:1] evt_flags,
    input  ctrl_t            ctrl,
    input  logic             done_flag,
    output logic             trig
);
    logic [N_SRC-1:0] cand;
    logic             sel_val;
    logic             prev_q;
    logic             fr_now;
    logic             fr_q;

    // candidate vector: slot 0 is the complete flag, the others are events
    for (genvar g = 0; g < N_SRC; g++) begin : g_cand
        if (g == 0) begin : g_free
            assign cand[g] = done_flag;
        end else begin : g_evt
            assign cand[g] = evt_flags[g];
        end
    end

    assign sel_val = ctrl.auto_en & cand[ctrl.sel];
    assign fr_now  = ctrl.auto_en && (ctrl.sel == SRC_FREE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            fr_q   <= 1'b0;
        end else begin
            prev_q <= sel_val;
            fr_q   <= fr_now;
        end
    end

    // entry into free running masks the edge (previous value treated as 1)
    assign trig = sel_val & ~prev_q & ~(fr_now & ~fr_q);
endmodule

// File: rtl/adc_trig_fsm.sv
module adc_trig_fsm
    import adc_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic conv_en,
    input  logic conv_done,
    output logic start_pulse,
    output logic busy
);
    conv_state_e st_q;
    conv_state_e st_nxt;
    logic        launch;
    logic        start_q;

    always_comb begin
        st_nxt = st_q;
        launch = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (trig && conv_en) begin
                    st_nxt = ST_CONVERT;
                    launch = 1'b1;
                end
            end
            ST_CONVERT: begin
                if (!conv_en || conv_done) begin
                    st_nxt = ST_IDLE;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            start_q <= 1'b0;
        end else begin
            st_q    <= st_nxt;
            start_q <= launch;
        end
    end

    always_comb begin
        busy        = (st_q == ST_CONVERT);
        start_pulse = start_q;
    end

    assert_start_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    assert_busy_with_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> busy);
    assert_done_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done) |=> !busy);
    assert_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_en) |=> !busy);
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
    import adc_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:1] evt_flags,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             conv_done,
    output logic             start_pulse,
    output logic             busy
);
    ctrl_t ctrl;
    logic  done_flag;
    logic  trig;
    logic  fr_sel;

    adc_trig_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wdata     (reg_wdata),
        .set_done  (conv_done),
        .ctrl      (ctrl),
        .done_flag (done_flag),
        .rdata     (reg_rdata)
    );

    adc_trig_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_flags (evt_flags),
        .ctrl      (ctrl),
        .done_flag (done_flag),
        .trig      (trig)
    );

    adc_trig_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig        (trig),
        .conv_en     (ctrl.conv_en),
        .conv_done   (conv_done),
        .start_pulse (start_pulse),
        .busy        (busy)
    );

    assign fr_sel = ctrl.auto_en && (ctrl.sel == SRC_FREE);

    assert_no_auto_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.auto_en |=> !start_pulse);
    assert_no_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.conv_en |=> !start_pulse);
    assert_freerun_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_sel && !$past(fr_sel)) |=> !start_pulse);
    assert_resv_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:RESV_LSB] == '0);
endmodule

// File: tb/sim_adc_trig_ctrl.sv
module sim_adc_trig_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:1] evt_flags = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       conv_done = 1'b0;
    logic       start_pulse;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    adc_trig_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .evt_flags(evt_flags), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_done(conv_done),
        .start_pulse(start_pulse), .busy(busy)
    );

    // {sel[2:0], flags[7:0], expected start}; flag bit 0 has no source
    localparam logic [11:0] VEC [11] = '{
        {3'd1, 8'h02, 1'b1}, {3'd2, 8'h04, 1'b1}, {3'd3, 8'h08, 1'b1},
        {3'd4, 8'h10, 1'b1}, {3'd5, 8'h20, 1'b1}, {3'd6, 8'h40, 1'b1},
        {3'd7, 8'h80, 1'b1}, {3'd3, 8'hF7, 1'b0}, {3'd5, 8'hDF, 1'b0},
        {3'd1, 8'hFD, 1'b0}, {3'd6, 8'hBF, 1'b0}
    };

    function automatic logic [7:0] cfg(input logic [2:0] s, input logic a,
                                       input logic e, input logic c);
        return {2'b00, c, e, a, s};
    endfunction

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic done_pulse();
        conv_done = 1'b1;
        step(1);
        conv_done = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 reg", reg_rdata, 8'h00);
        chk("R1 start", {7'd0, start_pulse}, 8'h0);
        chk("R1 busy", {7'd0, busy}, 8'h0);

        // R12: reserved bits
        wr(8'hFF);
        chk("R12 resv readback", reg_rdata, 8'h1F);
        wr(8'h00);

        // R2 R3: vector walk over every source
        foreach (VEC[i]) begin
            evt_flags = '0;
            wr(cfg(VEC[i][11:9], 1'b1, 1'b1, 1'b1));
            step(2);
            evt_flags = VEC[i][8:2];
            step(1);
            chk($sformatf("R2 vec%0d start", i), {7'd0, start_pulse}, {7'd0, VEC[i][0]});
            evt_flags = '0;
            if (busy) done_pulse();
            step(1);
        end

        // R4: auto disabled
        wr(cfg(3'd2, 1'b0, 1'b1, 1'b1));
        step(2);
        evt_flags = 7'h02;
        step(1);
        chk("R4 start", {7'd0, start_pulse}, 8'h0);
        step(1);
        chk("R4 busy", {7'd0, busy}, 8'h0);
        evt_flags = '0;

        // R5: converter disabled
        wr(cfg(3'd2, 1'b1, 1'b0, 1'b0));
        step(2);
        evt_flags = 7'h02;
        step(1);
        chk("R5 start", {7'd0, start_pulse}, 8'h0);
        step(1);
        chk("R5 busy", {7'd0, busy}, 8'h0);
        evt_flags = '0;
        step(1);

        // R3 R9 R11: edge, pulse width, busy release, flag
        wr(cfg(3'd2, 1'b1, 1'b1, 1'b0));
        step(1);
        evt_flags = 7'h02;
        step(1);
        chk("R3 start", {7'd0, start_pulse}, 8'h1);
        chk("R9 busy rise", {7'd0, busy}, 8'h1);
        step(1);
        chk("R9 single", {7'd0, start_pulse}, 8'h0);
        done_pulse();
        chk("R9 busy fall", {7'd0, busy}, 8'h0);
        chk("R11 flag set", {7'd0, reg_rdata[5]}, 8'h1);
        step(3);
        chk("R3 level held", {6'd0, start_pulse, busy}, 8'h0);
        evt_flags = '0;

        // R6: selection switch from low to high flag
        wr(cfg(3'd3, 1'b1, 1'b1, 1'b1));
        evt_flags = 7'h08;
        step(2);
        chk("R6 before", {7'd0, busy}, 8'h0);
        wr(cfg(3'd4, 1'b1, 1'b1, 1'b0));
        step(1);
        chk("R6 start", {7'd0, start_pulse}, 8'h1);
        done_pulse();
        evt_flags = '0;
        step(1);

        // R10: edge during busy dropped
        wr(cfg(3'd1, 1'b1, 1'b1, 1'b0));
        step(1);
        evt_flags = 7'h01;
        step(1);
        chk("R10 first", {7'd0, start_pulse}, 8'h1);
        evt_flags = '0;
        step(1);
        evt_flags = 7'h01;
        step(1);
        chk("R10 drop", {7'd0, start_pulse}, 8'h0);
        done_pulse();
        step(2);
        chk("R10 not held", {6'd0, start_pulse, busy}, 8'h0);
        evt_flags = '0;

        // R7: entering free running with flag already set
        wr(cfg(3'd0, 1'b1, 1'b1, 1'b0));
        step(1);
        chk("R7 sel entry", {7'd0, start_pulse}, 8'h0);
        step(2);
        chk("R7 sel busy", {7'd0, busy}, 8'h0);
        wr(cfg(3'd0, 1'b0, 1'b1, 1'b0));
        step(1);
        wr(cfg(3'd0, 1'b1, 1'b1, 1'b0));
        step(1);
        chk("R7 auto entry", {6'd0, start_pulse, busy}, 8'h0);

        // R11: set wins over clear in the same cycle
        reg_wr = 1'b1;
        reg_wdata = cfg(3'd0, 1'b1, 1'b1, 1'b1);
        conv_done = 1'b1;
        step(1);
        reg_wr = 1'b0;
        conv_done = 1'b0;
        chk("R11 set wins", {7'd0, reg_rdata[5]}, 8'h1);
        wr(cfg(3'd0, 1'b1, 1'b1, 1'b1));
        chk("R11 clear", {7'd0, reg_rdata[5]}, 8'h0);

        // R8: free running chain
        done_pulse();
        step(1);
        chk("R8 first", {7'd0, start_pulse}, 8'h1);
        wr(cfg(3'd0, 1'b1, 1'b1, 1'b1));
        done_pulse();
        step(1);
        chk("R8 chain", {7'd0, start_pulse}, 8'h1);

        // R5: abort
        wr(cfg(3'd0, 1'b1, 1'b0, 1'b1));
        step(1);
        chk("R5 abort", {7'd0, busy}, 8'h0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule